// File: doc/BRIEF.md
# Indirect Bus Command Bridge

This block lets software reach a 32-bit internal bus address space through four 64-bit registers. Every register access is a full 8-byte word. Software first writes a data word. It then writes a control word, and that write starts one bus operation at once. Software then reads a status register to learn that the operation finished and, for a read, to collect the returned bytes.

The bus side is a simple request/response master. The request is held, with stable address, size, direction and write data, until the responder acknowledges it. The acknowledge carries read data and an error flag. A failed read is reported only by all-ones read data. A write reports done whatever the responder answered. The status register clears itself when it is read. Only one operation is in flight at a time.

Top module: `cbr_top`

## Requirements
- R1: The register is picked by bits [4:3] of the byte offset: 0 control, 1 reset, 2 status, 3 data. All other offset bits are ignored.
- R2: Reads of the control and reset registers return zero. A data register read returns the stored word in bits [63:32] and zeros in bits [31:0]. A data write stores write-data bits [63:32].
- R3: A control write whose size field is at most 8 raises the bus request in the next cycle. The request carries address = control[31:0], size = control[59:56], and write direction when control bit 48 is 0 (read when it is 1). It stays high and stable until acknowledged.
- R4: A control write with a size field above 8 makes no bus request and leaves the status register unchanged. A size of exactly 8 is accepted.
- R5: A read that completes without error sets status bit 11. It loads status[57:26] with the 32 returned bits, and bus byte 0 (bus_rdata[31:23+1]) lands in the most significant position, status[57:50].
- R6: A read that completes with the error flag sets status bit 11 and loads status[57:26] with all ones.
- R7: A write drives bus_wdata with the stored data word, with byte 0 (data bits [63:56]) on bus_wdata[31:24]. On completion the status becomes exactly bit 11, whatever the error flag says.
- R8: A status read returns the current value and clears the register in the same access, so a second read returns zero.
- R9: While an operation is outstanding, control writes are ignored. Status reads return zero and do not clear the register.
- R10: After reset every register reads zero and no bus request is raised. Writes to the reset and status registers change nothing.
- R11: Every register read is answered by reg_rvalid with reg_rdata exactly one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = register write, 0 = register read |
| reg_off | input | 12 | Byte offset of the access |
| reg_wdata | input | 64 | Register write data |
| reg_rvalid | output | 1 | Read response valid |
| reg_rdata | output | 64 | Read response data |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_wr | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | 32 | Bus byte address |
| bus_size | output | 4 | Transfer size in bytes |
| bus_wdata | output | 32 | Write data, byte 0 in bits [31:24] |
| bus_ack | input | 1 | Responder acknowledge, one cycle |
| bus_err | input | 1 | Error flag, valid with bus_ack |
| bus_rdata | input | 32 | Read data, byte 0 in bits [31:24], valid with bus_ack |

## Verification
The assertions assume the following about the inputs. bus_ack is raised only while bus_req is high. bus_err and bus_rdata are meaningful only in the acknowledge cycle. reg_req is a one-cycle strobe whose controls are steady around the sampling edge. The bench's responder model meets these rules: it watches bus_req on the falling edge, acknowledges only a live request after a programmable delay, and drops the acknowledge in the cycle after. The bench drives every register access for exactly one cycle, between falling edges.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
   localparam int unsigned CBR_REG_W  = 64;
   localparam int unsigned CBR_BUS_AW = 32;
   localparam int unsigned CBR_BUS_DW = 32;
   localparam int unsigned CBR_SIZE_W = 4;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_RST  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_DATA = 2'd3
   } cbr_sel_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } cbr_state_e;

   typedef struct packed {
      logic                  is_read;
      logic [CBR_SIZE_W-1:0] size;
      logic [CBR_BUS_AW-1:0] addr;
   } cbr_cmd_t;

   typedef struct packed {
      logic                  err;
      logic                  is_read;
      logic [CBR_BUS_DW-1:0] rdata;
   } cbr_cpl_t;
endpackage

// File: rtl/cbr_cmd_decode.sv
module cbr_cmd_decode
   import cbr_pkg::*;
#(
   parameter int unsigned RD_BIT   = 48,
   parameter int unsigned SIZE_LSB = 56,
   parameter int unsigned ADDR_LSB = 0,
   parameter int unsigned MAX_SIZE = 8
) (
   input  logic [CBR_REG_W-1:0] ctrl_word,
   output cbr_cmd_t             cmd,
   output logic                 size_ok
);
   localparam logic [CBR_SIZE_W:0] MAX_V = (CBR_SIZE_W+1)'(MAX_SIZE);

   if (RD_BIT >= CBR_REG_W) begin : g_bad_rd
      $error("read flag outside control word");
   end
   if (SIZE_LSB + CBR_SIZE_W > CBR_REG_W) begin : g_bad_sz
      $error("size field outside control word");
   end
   if (ADDR_LSB + CBR_BUS_AW > CBR_REG_W) begin : g_bad_ad
      $error("address field outside control word");
   end
   if (MAX_SIZE < 1 || MAX_SIZE >= (1 << CBR_SIZE_W)) begin : g_bad_max
      $error("size limit not representable");
   end

   logic unused_ctrl;
   assign unused_ctrl = ^ctrl_word;

   always_comb begin
      cmd.is_read = ctrl_word[RD_BIT];
      cmd.size    = ctrl_word[SIZE_LSB +: CBR_SIZE_W];
      cmd.addr    = ctrl_word[ADDR_LSB +: CBR_BUS_AW];
      size_ok     = ({1'b0, cmd.size} <= MAX_V);
   end
endmodule

// File: rtl/cbr_bus_master.sv
module cbr_bus_master
   import cbr_pkg::*;
#(
   parameter int unsigned MAX_SIZE       = 8,
   parameter bit          BYTE_MSB_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  launch_req,
   input  cbr_cmd_t              cmd,
   input  logic [CBR_BUS_DW-1:0] wdata_word,
   output logic                  busy,
   output logic                  bus_req,
   output logic                  bus_wr,
   output logic [CBR_BUS_AW-1:0] bus_addr,
   output logic [CBR_SIZE_W-1:0] bus_size,
   output logic [CBR_BUS_DW-1:0] bus_wdata,
   input  logic                  bus_ack,
   input  logic                  bus_err,
   input  logic [CBR_BUS_DW-1:0] bus_rdata,
   output logic                  cpl_valid,
   output cbr_cpl_t              cpl
);
   localparam int unsigned NBYTES = CBR_BUS_DW / 8;
   localparam logic [CBR_SIZE_W:0] MAX_V = (CBR_SIZE_W+1)'(MAX_SIZE);

   if (CBR_BUS_DW % 8 != 0) begin : g_bad_dw
      $error("bus data width must be whole bytes");
   end

   cbr_state_e            state_q;
   cbr_cmd_t              cmd_q;
   logic [CBR_BUS_DW-1:0] wd_q;
   logic [CBR_BUS_DW-1:0] rd_lanes;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd_q   <= '0;
         wd_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (launch_req) begin
                  state_q <= ST_WAIT;
                  cmd_q   <= cmd;
                  wd_q    <= wdata_word;
               end
            end
            ST_WAIT: begin
               if (bus_ack) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      if (BYTE_MSB_FIRST) begin : g_be
         assign bus_wdata[8*b +: 8] = wd_q[8*b +: 8];
         assign rd_lanes[8*b +: 8]  = bus_rdata[8*b +: 8];
      end else begin : g_le
         assign bus_wdata[8*b +: 8] = wd_q[8*(NBYTES-1-b) +: 8];
         assign rd_lanes[8*b +: 8]  = bus_rdata[8*(NBYTES-1-b) +: 8];
      end
   end

   assign busy      = (state_q == ST_WAIT);
   assign bus_req   = busy;
   assign bus_wr    = ~cmd_q.is_read;
   assign bus_addr  = cmd_q.addr;
   assign bus_size  = cmd_q.size;
   assign cpl_valid = busy & bus_ack;

   always_comb begin
      cpl.err     = bus_err;
      cpl.is_read = cmd_q.is_read;
      cpl.rdata   = rd_lanes;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_size) && $stable(bus_wr))); // R3
   AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> ({1'b0, bus_size} <= MAX_V)); // R4
   AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && launch_req) |=> $stable(bus_wdata)); // R9
endmodule

// File: rtl/cbr_status.sv
module cbr_status
   import cbr_pkg::*;
#(
   parameter int unsigned DONE_BIT  = 11,
   parameter int unsigned RDATA_LSB = 26
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpl_valid,
   input  cbr_cpl_t             cpl,
   input  logic                 rd_stat,
   input  logic                 busy,
   output logic [CBR_REG_W-1:0] stat_rdata
);
   localparam logic [CBR_REG_W-1:0] DONE_MASK = CBR_REG_W'(1) << DONE_BIT;

   if (RDATA_LSB + CBR_BUS_DW > CBR_REG_W) begin : g_bad_field
      $error("read data field outside status word");
   end
   if (DONE_BIT >= RDATA_LSB && DONE_BIT < RDATA_LSB + CBR_BUS_DW) begin : g_overlap
      $error("done flag overlaps read data field");
   end

   logic [CBR_REG_W-1:0] status_q;
   logic [CBR_REG_W-1:0] status_nxt;

   always_comb begin
      status_nxt           = '0;
      status_nxt[DONE_BIT] = 1'b1;
      if (cpl.is_read) begin
         status_nxt[RDATA_LSB +: CBR_BUS_DW] = cpl.err ? '1 : cpl.rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
      end else if (cpl_valid) begin
         status_q <= status_nxt;
      end else if (rd_stat && !busy) begin
         status_q <= '0;
      end
   end

   assign stat_rdata = busy ? '0 : status_q;

   AST_DONE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q != '0) |-> status_q[DONE_BIT]); // R5
   AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl.is_read && cpl.err) |=> (&status_q[RDATA_LSB +: CBR_BUS_DW])); // R6
   AST_WRITE_DONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !cpl.is_read) |=> (status_q == DONE_MASK)); // R7
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !busy && !cpl_valid) |=> (status_q == '0)); // R8
   AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cpl_valid) |=> $stable(status_q)); // R9
endmodule

// File: rtl/cbr_top.sv
module cbr_top
   import cbr_pkg::*;
#(
   parameter int unsigned OFF_W          = 12,
   parameter int unsigned SEL_LSB        = 3,
   parameter int unsigned RD_BIT         = 48,
   parameter int unsigned SIZE_LSB       = 56,
   parameter int unsigned ADDR_LSB       = 0,
   parameter int unsigned MAX_SIZE       = 8,
   parameter int unsigned DONE_BIT       = 11,
   parameter int unsigned RDATA_LSB      = 26,
   parameter int unsigned DATA_LSB       = 32,
   parameter bit          BYTE_MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_req,
   input  logic              reg_wr,
   input  logic [OFF_W-1:0]  reg_off,
   input  logic [63:0]       reg_wdata,
   output logic              reg_rvalid,
   output logic [63:0]       reg_rdata,
   output logic              bus_req,
   output logic              bus_wr,
   output logic [31:0]       bus_addr,
   output logic [3:0]        bus_size,
   output logic [31:0]       bus_wdata,
   input  logic              bus_ack,
   input  logic              bus_err,
   input  logic [31:0]       bus_rdata
);
   if (SEL_LSB + 2 > OFF_W) begin : g_bad_sel
      $error("register select outside offset");
   end
   if (DATA_LSB + CBR_BUS_DW > CBR_REG_W) begin : g_bad_data
      $error("data field outside register");
   end
   if (CBR_REG_W != 64 || CBR_BUS_AW != 32 || CBR_BUS_DW != 32 || CBR_SIZE_W != 4) begin : g_bad_pkg
      $error("package widths disagree with port widths");
   end

   cbr_sel_e              sel;
   logic                  ctrl_wr, data_wr, stat_rd, rd_any;
   logic [CBR_BUS_DW-1:0] data_q;
   cbr_cmd_t              cmd;
   logic                  size_ok;
   logic                  busy;
   logic                  cpl_valid;
   cbr_cpl_t              cpl;
   logic [CBR_REG_W-1:0]  stat_rdata;
   logic [CBR_REG_W-1:0]  rd_mux;
   logic                  rvalid_q;
   logic [CBR_REG_W-1:0]  rdata_q;
   logic                  unused_off;

   assign unused_off = ^reg_off;
   assign sel     = cbr_sel_e'(reg_off[SEL_LSB +: 2]);
   assign rd_any  = reg_req & ~reg_wr;
   assign ctrl_wr = reg_req & reg_wr & (sel == SEL_CTRL);
   assign data_wr = reg_req & reg_wr & (sel == SEL_DATA);
   assign stat_rd = rd_any & (sel == SEL_STAT);

   cbr_cmd_decode #(
      .RD_BIT   (RD_BIT),
      .SIZE_LSB (SIZE_LSB),
      .ADDR_LSB (ADDR_LSB),
      .MAX_SIZE (MAX_SIZE)
   ) u_dec (
      .ctrl_word (reg_wdata),
      .cmd       (cmd),
      .size_ok   (size_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (data_wr) begin
         data_q <= reg_wdata[DATA_LSB +: CBR_BUS_DW];
      end
   end

   cbr_bus_master #(
      .MAX_SIZE       (MAX_SIZE),
      .BYTE_MSB_FIRST (BYTE_MSB_FIRST)
   ) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_req (ctrl_wr & size_ok),
      .cmd        (cmd),
      .wdata_word (data_q),
      .busy       (busy),
      .bus_req    (bus_req),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_size   (bus_size),
      .bus_wdata  (bus_wdata),
      .bus_ack    (bus_ack),
      .bus_err    (bus_err),
      .bus_rdata  (bus_rdata),
      .cpl_valid  (cpl_valid),
      .cpl        (cpl)
   );

   cbr_status #(
      .DONE_BIT  (DONE_BIT),
      .RDATA_LSB (RDATA_LSB)
   ) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpl_valid  (cpl_valid),
      .cpl        (cpl),
      .rd_stat    (stat_rd),
      .busy       (busy),
      .stat_rdata (stat_rdata)
   );

   always_comb begin
      case (sel)
         SEL_STAT: rd_mux = stat_rdata;
         SEL_DATA: rd_mux = {{(CBR_REG_W-CBR_BUS_DW){1'b0}}, data_q} << DATA_LSB;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= rd_any;
         rdata_q  <= rd_any ? rd_mux : '0;
      end
   end

   assign reg_rvalid = rvalid_q;
   assign reg_rdata  = rdata_q;

   AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_any |=> reg_rvalid); // R11
   AST_CTRL_RST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && (sel == SEL_CTRL || sel == SEL_RST)) |=> (reg_rdata == '0)); // R2
   AST_BUSY_STAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && busy) |=> (reg_rdata == '0)); // R9
   AST_BIG_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !size_ok && !busy) |=> !bus_req); // R4
   AST_LAUNCH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && size_ok && !busy) |=> (bus_req && bus_addr == $past(reg_wdata[ADDR_LSB +: CBR_BUS_AW]))); // R3
endmodule

// File: tb/cbr_top_test.sv
module cbr_top_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_req = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_off = '0;
   logic [63:0] reg_wdata = '0;
   logic        reg_rvalid;
   logic [63:0] reg_rdata;
   logic        bus_req, bus_wr;
   logic [31:0] bus_addr;
   logic [3:0]  bus_size;
   logic [31:0] bus_wdata;
   logic        bus_ack = 1'b0;
   logic        bus_err = 1'b0;
   logic [31:0] bus_rdata = '0;

   int          total = 0;
   int          bad = 0;
   int          resp_lat = 0;
   logic        resp_err = 1'b0;
   logic [31:0] resp_data = '0;
   int          ops_seen = 0;
   int          lat_cnt = 0;
   logic [31:0] last_addr = '0;
   logic [3:0]  last_size = '0;
   logic        last_wr = 1'b0;
   logic [31:0] last_wdata = '0;

   localparam logic [11:0] OFF_CTRL = 12'h000;
   localparam logic [11:0] OFF_RST  = 12'h008;
   localparam logic [11:0] OFF_STAT = 12'h010;
   localparam logic [11:0] OFF_DATA = 12'h018;
   localparam logic [63:0] DONE     = 64'h800;

   cbr_top uut (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
      .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
      .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
   );

   always #4 clk = ~clk;

   // responder model: acknowledges a live request after resp_lat cycles
   always @(negedge clk) begin
      if (bus_req && !bus_ack) begin
         if (lat_cnt >= resp_lat) begin
            bus_ack    = 1'b1;
            bus_err    = resp_err;
            bus_rdata  = resp_data;
            lat_cnt    = 0;
            ops_seen   = ops_seen + 1;
            last_addr  = bus_addr;
            last_size  = bus_size;
            last_wr    = bus_wr;
            last_wdata = bus_wdata;
         end else begin
            lat_cnt = lat_cnt + 1;
         end
      end else begin
         bus_ack   = 1'b0;
         bus_err   = 1'b0;
         bus_rdata = '0;
         lat_cnt   = 0;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] off, input logic [63:0] v);
      @(negedge clk);
      reg_req = 1'b1; reg_wr = 1'b1; reg_off = off; reg_wdata = v;
      @(negedge clk);
      reg_req = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_reg(input logic [11:0] off, output logic [63:0] v, output logic vld);
      @(negedge clk);
      reg_req = 1'b1; reg_wr = 1'b0; reg_off = off;
      @(negedge clk);
      reg_req = 1'b0;
      v = reg_rdata;
      vld = reg_rvalid;
   endtask

   function automatic logic [63:0] ctrl(input logic rd, input logic [3:0] sz, input logic [31:0] a);
      return (64'(sz) << 56) | (rd ? (64'h1 << 48) : 64'h0) | 64'(a);
   endfunction

   task automatic wait_ops(input int target);
      for (int i = 0; i < 200 && ops_seen < target; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [63:0] v; logic vld;
      chk("R10 bus_req after reset", 64'(bus_req), 64'h0);
      rd_reg(OFF_STAT, v, vld); chk("R10 status after reset", v, 64'h0);
      chk("R11 rvalid on read", 64'(vld), 64'h1);
      rd_reg(OFF_DATA, v, vld); chk("R10 data after reset", v, 64'h0);
   endtask

   task automatic t_regs();
      logic [63:0] v; logic vld;
      wr_reg(OFF_DATA, 64'hA1B2C3D4_55667788);
      rd_reg(OFF_DATA, v, vld); chk("R2 data readback", v, 64'hA1B2C3D4_00000000);
      rd_reg(OFF_CTRL, v, vld); chk("R2 control reads zero", v, 64'h0);
      rd_reg(OFF_RST, v, vld);  chk("R2 reset reads zero", v, 64'h0);
      rd_reg(12'h038, v, vld);  chk("R1 alias offset selects data", v, 64'hA1B2C3D4_00000000);
   endtask

   task automatic t_write_op();
      logic [63:0] v; logic vld; int n;
      n = ops_seen; resp_lat = 0; resp_err = 1'b1;
      wr_reg(OFF_CTRL, ctrl(1'b0, 4'd4, 32'hC001_2024));
      chk("R3 request one cycle after control write", 64'(bus_req), 64'h1);
      wait_ops(n + 1);
      chk("R3 write address", 64'(last_addr), 64'hC001_2024);
      chk("R3 write size", 64'(last_size), 64'h4);
      chk("R3 write direction", 64'(last_wr), 64'h1);
      chk("R7 write data byte order", 64'(last_wdata), 64'hA1B2C3D4);
      rd_reg(OFF_STAT, v, vld); chk("R7 status done only despite error", v, DONE);
      rd_reg(OFF_STAT, v, vld); chk("R8 status cleared by read", v, 64'h0);
      resp_err = 1'b0;
   endtask

   task automatic t_read_op();
      logic [63:0] v; logic vld; int n;
      n = ops_seen; resp_lat = 3; resp_data = 32'h1234_5678;
      wr_reg(OFF_CTRL, ctrl(1'b1, 4'd4, 32'hD001_0060));
      wait_ops(n + 1);
      chk("R3 read direction", 64'(last_wr), 64'h0);
      rd_reg(OFF_STAT, v, vld);
      chk("R5 read data packed", v, DONE | (64'h1234_5678 << 26));
   endtask

   task automatic t_read_err();
      logic [63:0] v; logic vld; int n;
      n = ops_seen; resp_lat = 1; resp_err = 1'b1; resp_data = 32'h0;
      wr_reg(OFF_CTRL, ctrl(1'b1, 4'd1, 32'h0000_0010));
      wait_ops(n + 1);
      rd_reg(OFF_STAT, v, vld);
      chk("R6 failed read gives all ones", v, DONE | (64'hFFFF_FFFF << 26));
      resp_err = 1'b0;
   endtask

   task automatic t_size_limit();
      logic [63:0] v; logic vld; int n;
      n = ops_seen; resp_lat = 0; resp_data = 32'hCAFE_0001;
      wr_reg(OFF_CTRL, ctrl(1'b1, 4'd8, 32'h0000_0100));
      wait_ops(n + 1);
      chk("R4 size 8 accepted", 64'(last_size), 64'h8);
      wr_reg(OFF_CTRL, ctrl(1'b1, 4'd9, 32'h0000_0200));
      repeat (5) @(negedge clk);
      chk("R4 size 9 makes no request", 64'(ops_seen), 64'(n + 1));
      wr_reg(OFF_CTRL, ctrl(1'b0, 4'd15, 32'h0000_0300));
      repeat (5) @(negedge clk);
      chk("R4 size 15 makes no request", 64'(ops_seen), 64'(n + 1));
      wr_reg(OFF_STAT, 64'h0);
      wr_reg(OFF_RST, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_reg(OFF_STAT, v, vld);
      chk("R4 R10 status kept", v, DONE | (64'hCAFE_0001 << 26));
   endtask

   task automatic t_busy();
      logic [63:0] v; logic vld; int n;
      n = ops_seen; resp_lat = 20; resp_data = 32'h0BAD_F00D;
      wr_reg(OFF_CTRL, ctrl(1'b1, 4'd4, 32'h1111_0000));
      wr_reg(OFF_CTRL, ctrl(1'b0, 4'd2, 32'h2222_0000));
      rd_reg(OFF_STAT, v, vld); chk("R9 status zero while busy", v, 64'h0);
      wait_ops(n + 1);
      repeat (30) @(negedge clk);
      chk("R9 second control write ignored", 64'(ops_seen), 64'(n + 1));
      chk("R9 first address kept", 64'(last_addr), 64'h1111_0000);
      rd_reg(OFF_STAT, v, vld);
      chk("R9 busy read did not clear", v, DONE | (64'h0BAD_F00D << 26));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_write_op();
      t_read_op();
      t_read_err();
      t_size_limit();
      t_busy();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule